// File: doc/BRIEF.md
# Control Register Target with Software Reset Lock

This block is a small register target on a host read/write port. It holds three 32-bit words. The first is a system control word that carries a software reset flag, a wait-state count and the direction bits for eight general-purpose pins. The second is a pin data word. The third is a base-address word aligned to 32-bit boundaries. The block drives an active-low "core in reset" line and a "DMA allowed" gate to the rest of the device. It also drives eight bidirectional pins through separate output-enable and output-value ports, and reads them back through a synchronizer.

After a hardware reset the core is held in reset by the software flag. The host must write a one to that flag to let the device run. While the flag is zero, all other registers keep their default values and ignore host writes. The host port still answers every access. Every access is delayed by the programmed number of wait states before a single-cycle ready pulse.

Top module: `ctl_reg_slave`

## Requirements
- R1: After hardware reset (`rst_n` low), `core_rst_n` and `dma_allow` are 0 and `gpio_oe` is 0x00. The reads are: 0x0000_00FF at offset 0x28, {synchronized pins, 24'h0} at 0x2C, and 0xFFFF_FFFC at 0x30. `gpio_out` is 0xF0.
- R2: Bit 24 of offset 0x28 (byte lane 3) is the run flag. Writing 1 drives `core_rst_n` and `dma_allow` to 1. Writing 0 drives both back to 0. Both outputs equal the flag at all times.
- R3: While the run flag is 0, writes to every other field are ignored. This includes the other fields of the write that sets the flag to 1.
- R4: When the run flag goes to 0, the wait-state count returns to 0, the direction to 0xFF, the pin data to 0xF0 and the base to 0xFFFF_FFFC. All four are restored on the same edge.
- R5: Bits 18:16 of offset 0x28 (byte lane 2) hold the wait count N. An access first seen with `req_valid` high at rising edge k gets `req_ready` high during the cycle after edge k+1+N. N is the value held at edge k.
- R6: `req_ready` is high for exactly one cycle. The requester holds its request until ready. No new access is accepted in the cycle in which ready is high.
- R7: Bits 7:0 of offset 0x28 (byte lane 0) set the pin directions, where 1 means input and 0 means output. `gpio_oe` is the bitwise inverse of the direction.
- R8: Bits 31:24 of offset 0x2C (byte lane 3) hold the pin data, which is driven on `gpio_out`. A write changes only the bits configured as outputs.
- R9: Reading offset 0x2C returns, in bits 31:24, the pin data for output bits and `gpio_in` for input bits. The input value is taken through a two-flop synchronizer.
- R10: At offset 0x30, bits 31:2 are writable and bits 1:0 always read 0, whatever is written.
- R11: Reserved bits read 0: bits 31:25, 23:19 and 15:8 at 0x28, and bits 23:0 at 0x2C. Unmapped offsets read 0x0000_0000.
- R12: A write changes only the byte lanes whose `req_be` bit is 1.
- R13: Read data appears on `req_rdata` during the ready cycle. It reflects the register state before any write made by the same access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hardware reset, active low, asynchronous |
| req_valid | input | 1 | Access request, held until ready |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset of the word |
| req_wdata | input | 32 | Write data |
| req_be | input | 4 | Byte-lane write enables |
| req_ready | output | 1 | One-cycle completion pulse |
| req_rdata | output | 32 | Read data, valid while ready |
| core_rst_n | output | 1 | Core reset to the device, active low |
| dma_allow | output | 1 | Gate that permits bus-master transfers |
| gpio_in | input | GPIO_N | Sampled pin levels |
| gpio_oe | output | GPIO_N | Per-pin output enable |
| gpio_out | output | GPIO_N | Per-pin output value |

## Verification
Each failure mode shows at the ports within a few cycles:

- A lock that fails to hold shows on the next read of the control, pin or base word. A stale field can survive a write to zero or a release write.
- The same lock fault can also show on `gpio_oe` and `gpio_out` one edge after the access.
- A wait counter loaded with the wrong value, or never reloaded, shifts the ready pulse by whole cycles. The measured latency of each access catches this at once.
- A synchronizer of the wrong depth or a wrong read mux shows as a wrong pin read a few cycles after the pins change.

// File: rtl/ctl_pkg.sv
package ctl_pkg;

  localparam logic [7:0] OFS_CTRL = 8'h28;
  localparam logic [7:0] OFS_GPIO = 8'h2C;
  localparam logic [7:0] OFS_BASE = 8'h30;

  localparam logic [7:0]  DIR_DFLT  = 8'hFF;
  localparam logic [7:0]  DAT_DFLT  = 8'hF0;
  localparam logic [31:0] BASE_DFLT = 32'hFFFF_FFFC;

  // only bits marked as output (dir = 0) take the new value
  function automatic logic [7:0] pin_merge(input logic [7:0] cur,
                                           input logic [7:0] nxt,
                                           input logic [7:0] dir);
    return (cur & dir) | (nxt & ~dir);
  endfunction

  // per byte-lane update of a 32-bit word
  function automatic logic [31:0] lane_merge(input logic [31:0] cur,
                                             input logic [31:0] nxt,
                                             input logic [3:0]  be);
    logic [31:0] m;
    for (int i = 0; i < 4; i++) m[i*8 +: 8] = be[i] ? nxt[i*8 +: 8] : cur[i*8 +: 8];
    return m;
  endfunction

  // read value of the pin byte: inputs from the synchronizer, outputs from the data register
  function automatic logic [7:0] pin_view(input logic [7:0] dat,
                                          input logic [7:0] pins,
                                          input logic [7:0] dir);
    return (pins & dir) | (dat & ~dir);
  endfunction

endpackage

// File: rtl/slv_handshake.sv
module slv_handshake #(
  parameter int WS_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            valid,
  input  logic [WS_W-1:0] ws,
  output logic            ready,
  output logic            commit
);

  logic            busy_q;
  logic [WS_W-1:0] cnt_q;
  logic            accept;

  assign accept = valid && !busy_q && !ready;
  assign commit = busy_q && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      ready  <= 1'b0;
    end else begin
      ready <= 1'b0;
      if (accept) begin
        busy_q <= 1'b1;
        cnt_q  <= ws;
      end else if (busy_q) begin
        if (cnt_q == '0) begin
          busy_q <= 1'b0;
          ready  <= 1'b1;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  // R6
  ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) ready |=> !ready);
  // R5
  commit_ready_chk: assert property (@(posedge clk) disable iff (!rst_n) commit |=> ready);
  // R6
  no_accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !commit) |=> (busy_q && cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q[0] <= '0;
    else        stg_q[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[s] <= '0;
      else        stg_q[s] <= stg_q[s-1];
    end
  end

  assign q = stg_q[STAGES-1];

endmodule

// File: rtl/ctl_regs.sv
module ctl_regs
  import ctl_pkg::*;
#(
  parameter int WS_W   = 3,
  parameter int GPIO_N = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              sel_ctrl,
  input  logic              sel_gpio,
  input  logic              sel_base,
  input  logic [31:0]       wdata,
  input  logic [3:0]        be,
  output logic              run_q,
  output logic [WS_W-1:0]   ws_q,
  output logic [GPIO_N-1:0] dir_q,
  output logic [GPIO_N-1:0] dat_q,
  output logic [31:2]       base_q
);

  logic wr_ctrl, wr_gpio, wr_base;
  logic run_nxt;
  logic lock;
  logic [31:0] base_m;

  assign wr_ctrl = wr_en && sel_ctrl;
  assign wr_gpio = wr_en && sel_gpio;
  assign wr_base = wr_en && sel_base;

  assign run_nxt = (wr_ctrl && be[3]) ? wdata[24] : run_q;
  // registers stay at default while in reset, and return to it on the edge reset is entered
  assign lock    = !run_q || !run_nxt;
  assign base_m  = lane_merge({base_q, 2'b00}, wdata, be);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      ws_q   <= '0;
      dir_q  <= GPIO_N'(DIR_DFLT);
      dat_q  <= GPIO_N'(DAT_DFLT);
      base_q <= BASE_DFLT[31:2];
    end else begin
      run_q <= run_nxt;
      if (lock) begin
        ws_q   <= '0;
        dir_q  <= GPIO_N'(DIR_DFLT);
        dat_q  <= GPIO_N'(DAT_DFLT);
        base_q <= BASE_DFLT[31:2];
      end else begin
        if (wr_ctrl && be[2]) ws_q  <= wdata[16 +: WS_W];
        if (wr_ctrl && be[0]) dir_q <= wdata[GPIO_N-1:0];
        if (wr_gpio && be[3]) dat_q <= pin_merge(dat_q, wdata[31:24], dir_q);
        if (wr_base)          base_q <= base_m[31:2];
      end
    end
  end

  // R4
  rst_dflt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> (ws_q == '0 && dir_q == GPIO_N'(DIR_DFLT) && dat_q == GPIO_N'(DAT_DFLT)
                && base_q == BASE_DFLT[31:2]));
  // R8
  input_bits_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && $past(run_q) && $stable(dir_q)) |-> ((dat_q & dir_q) == ($past(dat_q) & dir_q)));
  // R3
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && $past(!run_q)) |-> ($stable(ws_q) && $stable(base_q)));

endmodule

// File: rtl/ctl_reg_slave.sv
module ctl_reg_slave
  import ctl_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int WS_W   = 3,
  parameter int GPIO_N = 8,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  input  logic [3:0]        req_be,
  output logic              req_ready,
  output logic [31:0]       req_rdata,
  output logic              core_rst_n,
  output logic              dma_allow,
  input  logic [GPIO_N-1:0] gpio_in,
  output logic [GPIO_N-1:0] gpio_oe,
  output logic [GPIO_N-1:0] gpio_out
);

  localparam int WS_HI = 16 + WS_W;

  logic              commit;
  logic              sel_ctrl, sel_gpio, sel_base;
  logic              run_q;
  logic [WS_W-1:0]   ws_q;
  logic [GPIO_N-1:0] dir_q, dat_q, pins_s;
  logic [31:2]       base_q;
  logic [31:0]       rd_mux;
  logic [31:0]       rdata_q;

  assign sel_ctrl = (req_addr == ADDR_W'(OFS_CTRL));
  assign sel_gpio = (req_addr == ADDR_W'(OFS_GPIO));
  assign sel_base = (req_addr == ADDR_W'(OFS_BASE));

  slv_handshake #(.WS_W(WS_W)) u_hs (
    .clk(clk), .rst_n(rst_n), .valid(req_valid), .ws(ws_q),
    .ready(req_ready), .commit(commit)
  );

  ctl_regs #(.WS_W(WS_W), .GPIO_N(GPIO_N)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(commit && req_write),
    .sel_ctrl(sel_ctrl), .sel_gpio(sel_gpio), .sel_base(sel_base),
    .wdata(req_wdata), .be(req_be),
    .run_q(run_q), .ws_q(ws_q), .dir_q(dir_q), .dat_q(dat_q), .base_q(base_q)
  );

  pin_sync #(.W(GPIO_N), .STAGES(SYNC_N)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(gpio_in), .q(pins_s)
  );

  always_comb begin
    rd_mux = '0;
    if (sel_ctrl) begin
      rd_mux[24]            = run_q;
      rd_mux[WS_HI-1:16]    = ws_q;
      rd_mux[GPIO_N-1:0]    = dir_q;
    end else if (sel_gpio) begin
      rd_mux[31:24] = pin_view(dat_q, pins_s, dir_q);
    end else if (sel_base) begin
      rd_mux = {base_q, 2'b00};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (commit) rdata_q <= rd_mux;
  end

  assign req_rdata  = rdata_q;
  assign core_rst_n = run_q;
  assign dma_allow  = run_q;
  assign gpio_oe    = ~dir_q;
  assign gpio_out   = dat_q;

  // R1
  reset_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !core_rst_n |-> (!dma_allow && gpio_oe == '0));
  // R13
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(req_rdata));

endmodule

// File: tb/ctl_reg_slave_bench.sv
module ctl_reg_slave_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [3:0]  req_be = '0;
  logic        req_ready;
  logic [31:0] req_rdata;
  logic        core_rst_n, dma_allow;
  logic [7:0]  gpio_in = 8'h5A;
  logic [7:0]  gpio_oe, gpio_out;

  int n_chk = 0;
  int n_fail = 0;

  // bench model of the register state
  logic       m_run;
  logic [2:0] m_ws;
  logic [7:0] m_dir, m_dat;
  logic [31:0] m_base;

  always #5 clk = ~clk;

  ctl_reg_slave u_ctl_reg_slave (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .req_ready(req_ready), .req_rdata(req_rdata), .core_rst_n(core_rst_n),
    .dma_allow(dma_allow), .gpio_in(gpio_in), .gpio_oe(gpio_oe), .gpio_out(gpio_out)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_read(input logic [7:0] a);
    logic [31:0] r = '0;
    if (a == 8'h28) r = {7'b0, m_run, 5'b0, m_ws, 8'b0, m_dir};
    else if (a == 8'h2C) r = {((gpio_in & m_dir) | (m_dat & ~m_dir)), 24'h0};
    else if (a == 8'h30) r = m_base;
    return r;
  endfunction

  function automatic logic [7:0] lane(input logic [7:0] o, input logic [7:0] n, input bit en);
    return en ? n : o;
  endfunction

  task automatic model_write(input logic [7:0] a, input logic [31:0] wd, input logic [3:0] be);
    logic nrun = (a == 8'h28 && be[3]) ? wd[24] : m_run;
    if (!m_run || !nrun) begin
      m_ws = 3'd0; m_dir = 8'hFF; m_dat = 8'hF0; m_base = 32'hFFFF_FFFC;
    end else begin
      if (a == 8'h28 && be[2]) m_ws = wd[18:16];
      if (a == 8'h28 && be[0]) m_dir = wd[7:0];
      if (a == 8'h2C && be[3]) m_dat = (m_dat & m_dir) | (wd[31:24] & ~m_dir);
      if (a == 8'h30) begin
        m_base[31:24] = lane(m_base[31:24], wd[31:24], be[3]);
        m_base[23:16] = lane(m_base[23:16], wd[23:16], be[2]);
        m_base[15:8]  = lane(m_base[15:8],  wd[15:8],  be[1]);
        m_base[7:0]   = lane(m_base[7:0],   wd[7:0],   be[0]);
        m_base[1:0]   = 2'b00;
      end
    end
    m_run = nrun;
  endtask

  // one access; checks latency (R5/R6), read data (R13 and others) and outputs
  task automatic access(input bit wr, input logic [7:0] a, input logic [31:0] wd,
                        input logic [3:0] be, input string req);
    int lat = 0;
    int exp_lat = 2 + int'(m_ws);
    logic [31:0] exp_rd = exp_read(a);
    req_write = wr; req_addr = a; req_wdata = wd; req_be = be; req_valid = 1'b1;
    do begin
      @(negedge clk);
      lat++;
    end while (!req_ready && lat < 100);
    check(lat == exp_lat, "R5 latency", lat, exp_lat);
    check(req_rdata == exp_rd, req, req_rdata, exp_rd);
    req_valid = 1'b0;
    if (wr) model_write(a, wd, be);
    @(negedge clk);
    check(!req_ready, "R6 single pulse", {31'b0, req_ready}, 0);
    check(core_rst_n == m_run && dma_allow == m_run, "R2 run outputs",
          {core_rst_n, dma_allow}, {m_run, m_run});
    check(gpio_oe == ~m_dir, "R7 oe", gpio_oe, ~m_dir);
    check(gpio_out == m_dat, "R8 out", gpio_out, m_dat);
  endtask

  task automatic set_pins(input logic [7:0] v);
    gpio_in = v;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd1357));
    m_run = 0; m_ws = 0; m_dir = 8'hFF; m_dat = 8'hF0; m_base = 32'hFFFF_FFFC;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(core_rst_n == 0 && dma_allow == 0, "R1 core held", {core_rst_n, dma_allow}, 0);
    check(gpio_oe == 8'h00, "R1 oe", gpio_oe, 0);
    check(gpio_out == 8'hF0, "R1 out", gpio_out, 8'hF0);
    access(0, 8'h28, 0, 0, "R1 ctrl default");
    access(0, 8'h2C, 0, 0, "R1 gpio default");
    access(0, 8'h30, 0, 0, "R1 base default");
    access(0, 8'h34, 0, 0, "R11 unmapped");
    // R3: writes in reset are ignored
    access(1, 8'h28, 32'h0007_00AA, 4'hF, "R3 ctrl write in reset");
    access(1, 8'h30, 32'h1234_5678, 4'hF, "R3 base write in reset");
    access(1, 8'h2C, 32'h0000_0000, 4'hF, "R3 gpio write in reset");
    access(0, 8'h28, 0, 0, "R3 ctrl after locked write");
    access(0, 8'h30, 0, 0, "R3 base after locked write");
    // R2/R3 release: other fields of the releasing write are dropped
    access(1, 8'h28, 32'h0107_0000, 4'hF, "R2 release");
    access(0, 8'h28, 0, 0, "R3 release drops fields");
    // R5 wait states
    access(1, 8'h28, 32'h0103_0000, 4'h4, "R5 set ws3");
    access(0, 8'h28, 0, 0, "R5 read with ws3");
    access(1, 8'h28, 32'h0107_0000, 4'h4, "R5 set ws7");
    access(0, 8'h30, 0, 0, "R5 read with ws7");
    // R7/R8/R9 pins
    access(1, 8'h28, 32'h0100_000F, 4'hD, "R7 dir split");
    access(1, 8'h2C, 32'hAA00_0000, 4'h8, "R8 partial output write");
    set_pins(8'h3C);
    access(0, 8'h2C, 0, 0, "R9 mixed pin read");
    set_pins(8'hC3);
    access(0, 8'h2C, 0, 0, "R9 pin change");
    access(1, 8'h2C, 32'h5500_0000, 4'h7, "R12 lane3 off");
    // R10/R12 base
    access(1, 8'h30, 32'h1234_5677, 4'hF, "R10 base write");
    access(0, 8'h30, 0, 0, "R10 low bits zero");
    access(1, 8'h30, 32'hABCD_EF03, 4'h2, "R12 single lane");
    access(0, 8'h30, 0, 0, "R12 base after lane write");
    access(0, 8'h38, 0, 0, "R11 unmapped");
    // R4 enter reset restores defaults
    access(1, 8'h28, 32'h0000_0000, 4'h8, "R4 enter reset");
    access(0, 8'h28, 0, 0, "R4 ctrl default again");
    access(0, 8'h30, 0, 0, "R4 base default again");
    // random mix
    for (int i = 0; i < 300; i++) begin
      logic [31:0] r = $urandom;
      logic [7:0] a;
      logic [31:0] wd = $urandom;
      case (r[1:0])
        2'd0: a = 8'h28;
        2'd1: a = 8'h2C;
        2'd2: a = 8'h30;
        default: a = {r[7:2], 2'b00};
      endcase
      if (a == 8'h28 && r[9:8] != 0) wd[24] = 1'b1;
      wd[18] = 1'b0;
      if (r[12:10] == 0) set_pins(r[23:16]);
      access(r[13], a, wd, r[17:14], "R13 random access");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule